// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

This block is a free-running 64-bit master time counter whose count rate stays fixed while the reference clock that drives it may be any of several frequencies. On every reference clock edge a programmable fraction, a numerator over a denominator, is added to a remainder accumulator. The visible count steps by one each time the remainder reaches a whole unit. With the ratio chosen to match the reference frequency, the count advances at 6.144 MHz.

Software programs the ratio through a small 32-bit register port. The same port gives a coherent read of the 64-bit count in two words. The count is also driven straight out to the local timer consumers. When the reference clock is switched, software writes the new ratio. The accumulator takes it on the next edge and reduces any remainder that is now too large, so the count never jumps by more than one.

Top module: `rtc_frac_counter`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), count_o, read data, the remainder, and both ratio registers are zero.
- R2: On each clock edge with a nonzero denominator, the numerator is added to the remainder. If the sum is greater than or equal to the denominator, count_o increments by one and the remainder becomes the sum minus the denominator. If that result is still at or above the denominator, the remainder becomes zero. The count never advances by more than one per clock.
- R3: Starting from reset, with the ratio programmed, count_o after N clocks equals floor(N × num / den) for each of 4/25, 8/25, 384/1625, 256/1125, 768/1625 and 64/125.
- R4: The numerator register is at byte offset 0x10 and the denominator register is at 0x14. A write stores all 32 bits and a read returns them unchanged. Only bits [11:0] form the ratio.
- R5: A ratio written at one clock edge is used by the accumulator from the following edge. A remainder that is at or above the new denominator is reduced on that edge.
- R6: While the denominator is zero, count_o and the remainder hold their values.
- R7: Read data appears on rdata_o the cycle after rd_en_i and holds until the next read. A read of offset 0x00 returns count bits [31:0] and latches count bits [63:32] into a shadow. A read of 0x04 returns that shadow. Any other offset reads zero.
- R8: If the numerator is at or above a nonzero denominator, count_o advances on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| count_o | output | 64 | Free-running count value |

## Verification
The hardest state to reach is a remainder that is larger than a denominator written later. Only a long run at a large denominator can build such a remainder. The bench runs 1500 clocks at 1/2000 and then writes a denominator of 25. It checks that exactly one step follows and that the remainder restarts from zero. Overprogrammed ratios and a zero denominator are also reached purely through register writes. A behavioural model follows every clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int OFS_CNT_LO = 'h00;
  localparam int OFS_CNT_HI = 'h04;
  localparam int OFS_NUM    = 'h10;
  localparam int OFS_DEN    = 'h14;
endpackage

// File: rtl/rtc_frac_accum.sv
module rtc_frac_accum #(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FRAC_W-1:0] num_i,
  input  logic [FRAC_W-1:0] den_i,
  output logic              step_o
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] rem_q;
  logic [FRAC_W-1:0] rem_nxt;
  logic [SUM_W-1:0]  sum;
  logic [SUM_W-1:0]  den_ext;
  logic [SUM_W-1:0]  diff;
  logic              hit;

  always_comb begin
    sum     = {1'b0, rem_q} + {1'b0, num_i};
    den_ext = {1'b0, den_i};
    diff    = sum - den_ext;
    hit     = (den_i != '0) && (sum >= den_ext);
    if (den_i == '0)
      rem_nxt = rem_q;
    else if (hit)
      rem_nxt = (diff >= den_ext) ? '0 : diff[FRAC_W-1:0];
    else
      rem_nxt = sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) rem_q <= '0;
    else     rem_q <= rem_nxt;
  end

  assign step_o = hit;

  assert_rem_below_den_R2: assert property (@(posedge clk) disable iff (rst)
    (den_i != '0) |=> (rem_q < $past(den_i)));
endmodule

// File: rtl/rtc_count64.sv
module rtc_count64 #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst)         count_o <= '0;
    else if (step_i) count_o <= count_o + 1'b1;
  end

  assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [FRAC_W-1:0] num_o,
  output logic [FRAC_W-1:0] den_o
);
  import rtc_pkg::*;
  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] num_q;
  logic [DATA_W-1:0] den_q;
  logic [HI_W-1:0]   shadow_q;
  logic              sel_lo, sel_hi, sel_num, sel_den;

  always_comb begin
    sel_lo  = addr_i == ADDR_W'(OFS_CNT_LO);
    sel_hi  = addr_i == ADDR_W'(OFS_CNT_HI);
    sel_num = addr_i == ADDR_W'(OFS_NUM);
    sel_den = addr_i == ADDR_W'(OFS_DEN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q <= '0;
      den_q <= '0;
    end else if (wr_en_i) begin
      if (sel_num) num_q <= wdata_i;
      if (sel_den) den_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      shadow_q <= '0;
    end else if (rd_en_i) begin
      if (sel_lo) begin
        rdata_o  <= count_i[DATA_W-1:0];
        shadow_q <= count_i[CNT_W-1:DATA_W];
      end else if (sel_hi)  rdata_o <= DATA_W'(shadow_q);
      else if (sel_num)     rdata_o <= num_q;
      else if (sel_den)     rdata_o <= den_q;
      else                  rdata_o <= '0;
    end
  end

  assign num_o = num_q[FRAC_W-1:0];
  assign den_o = den_q[FRAC_W-1:0];

  assert_shadow_latch_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && sel_lo) |=> (shadow_q == $past(count_i[CNT_W-1:DATA_W])));
endmodule

// File: rtl/rtc_frac_counter.sv
module rtc_frac_counter #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [FRAC_W-1:0] num_w;
  logic [FRAC_W-1:0] den_w;
  logic              step_w;

  rtc_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .FRAC_W(FRAC_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .count_i(count_o), .rdata_o(rdata_o), .num_o(num_w), .den_o(den_w)
  );

  rtc_frac_accum #(.FRAC_W(FRAC_W)) accum_i (
    .clk(clk), .rst(rst), .num_i(num_w), .den_i(den_w), .step_o(step_w)
  );

  rtc_count64 #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst(rst), .step_i(step_w), .count_o(count_o)
  );

  assert_zero_den_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (den_w == '0) |=> $stable(count_o));
endmodule

// File: tb/rtc_frac_counter_tb_top.sv
`timescale 1ns/1ps
module rtc_frac_counter_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0, rd_en = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] count;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  // behavioural model
  longint unsigned m_cnt = 0;
  int m_rem = 0;
  logic [31:0] m_num = 0, m_den = 0, m_rdata = 0, m_shadow = 0;

  always #5 clk = ~clk;

  rtc_frac_counter dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .count_o(count)
  );

  always @(posedge clk) begin
    int n, d, s;
    if (rst) begin
      m_cnt = 0; m_rem = 0; m_num = 0; m_den = 0; m_rdata = 0; m_shadow = 0;
    end else begin
      if (rd_en) begin
        case (addr)
          5'h00: begin m_rdata = m_cnt[31:0]; m_shadow = m_cnt[63:32]; end
          5'h04: m_rdata = m_shadow;
          5'h10: m_rdata = m_num;
          5'h14: m_rdata = m_den;
          default: m_rdata = 0;
        endcase
      end
      n = int'(m_num[11:0]);
      d = int'(m_den[11:0]);
      if (d != 0) begin
        s = m_rem + n;
        if (s >= d) begin
          m_cnt = m_cnt + 1;
          m_rem = s - d;
          if (m_rem >= d) m_rem = 0;
        end else m_rem = s;
      end
      if (wr_en) begin
        if (addr == 5'h10) m_num = wdata;
        if (addr == 5'h14) m_den = wdata;
      end
    end
  end

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 count vs model", count, m_cnt);
      check("R7 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic run_ratio(input int num, input int den, input int n);
    longint unsigned exp;
    do_reset();
    bus_write(5'h10, 32'(num));
    bus_write(5'h14, 32'(den));
    repeat (n) @(negedge clk);
    exp = (longint'(n) * num) / den;
    check($sformatf("R3 floor %0d/%0d", num, den), count, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #2ms;
    n_checks++; n_errors++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    longint unsigned snap;
    repeat (3) @(negedge clk);
    rst = 0;
    do_reset();
    // R1
    check("R1 count after reset", count, 0);
    check("R1 rdata after reset", rdata, 0);
    bus_read(5'h10, rd); check("R1 num after reset", rd, 0);
    bus_read(5'h14, rd); check("R1 den after reset", rd, 0);

    // R3 each ratio pair
    run_ratio(4, 25, 4000);
    run_ratio(8, 25, 4000);
    run_ratio(384, 1625, 4000);
    run_ratio(256, 1125, 4000);
    run_ratio(768, 1625, 4000);
    run_ratio(64, 125, 4000);

    // R4 upper bits kept, only low 12 used
    do_reset();
    bus_write(5'h10, 32'hFFFFF004);
    bus_write(5'h14, 32'h12345019);
    snap = count;
    bus_read(5'h10, rd); check("R4 num readback", rd, 32'hFFFFF004);
    bus_read(5'h14, rd); check("R4 den readback", rd, 32'h12345019);
    repeat (996) @(negedge clk);
    check("R4 low field ratio", count, 160);

    // R5 remainder above new denominator
    do_reset();
    bus_write(5'h10, 1);
    bus_write(5'h14, 2000);
    repeat (1500) @(negedge clk);
    check("R5 before switch", count, 0);
    bus_write(5'h14, 25);
    check("R5 old ratio until write edge", count, 0);
    @(negedge clk);
    check("R5 single step on switch", count, 1);
    repeat (25) @(negedge clk);
    check("R5 remainder restarted", count, 2);

    // R6 zero denominator holds
    bus_write(5'h10, 20);
    bus_write(5'h14, 0);
    snap = count;
    repeat (100) @(negedge clk);
    check("R6 hold with zero den", count, snap);
    bus_write(5'h14, 25);
    repeat (5) @(negedge clk);
    check("R6 resumes", count, snap + 4);

    // R7 coherent split read and unmapped offset
    bus_write(5'h10, 64);
    bus_write(5'h14, 125);
    repeat (37) @(negedge clk);
    @(negedge clk); rd_en = 1; addr = 5'h00; snap = count;
    @(negedge clk); rd_en = 0; rd = rdata;
    check("R7 low word", rd, snap & 64'hFFFF_FFFF);
    repeat (300) @(negedge clk);
    bus_read(5'h04, rd); check("R7 shadow high word", rd, snap >> 32);
    bus_read(5'h08, rd); check("R7 unmapped reads zero", rd, 0);
    @(negedge clk);
    check("R7 rdata holds", rdata, 0);

    // R8 numerator at or above denominator
    do_reset();
    bus_write(5'h10, 30);
    bus_write(5'h14, 25);
    snap = count;
    repeat (50) @(negedge clk);
    check("R8 step every clock", count, snap + 50);
    bus_write(5'h10, 25);
    snap = count;
    repeat (10) @(negedge clk);
    check("R8 equal num den", count, snap + 10);

    finish_run();
  end
endmodule